// File: doc/BRIEF.md
# Single-Channel DMA Controller with Direct-Mode Write Start

This block is one DMA channel with a small register file. Software fills in the byte count, the attributes and the mode word. A single store to one of the two address registers then launches a copy. A mode bit picks which of the two address registers launches it. On a launch the hardware raises the channel-start bit on its own, so software never writes that bit.

While the channel is busy, a byte engine moves data on a generic memory port, one byte at a time. It reads one byte from the source and then writes it to the destination. It keeps doing this until its working copy of the count reaches zero. The channel stops early on a rising edge of the abort bit, or when the memory port returns an error. The status register holds a busy flag and three sticky flags: done, error and aborted. The interrupt line is the done flag gated by its enable bit.

Register map (word offsets on `reg_addr`):
- 0 mode: bit 0 start (hardware only), bit 1 abort, bit 2 direct, bit 3 single-write enable, bit 4 trigger select, bit 5 done-interrupt enable.
- 1 status: bit 0 busy (read-only), bit 1 done, bit 2 error, bit 3 aborted.
- 2 source address.
- 3 destination address.
- 4 byte count.
- 5 source attribute.
- 6 destination attribute.

Top module: `dma_direct_ctrl`

## Requirements
- R1: A write to an address register can launch a transfer only while mode bits 2 (direct) and 3 (single-write enable) are both 1. Otherwise no address write sets status bit 0 (busy), and no memory request is issued.
- R2: With mode bit 4 at 1, a write to offset 2 (source) launches the transfer. With mode bit 4 at 0, a write to offset 3 (destination) launches it. Busy reads 1 in the cycle after the launching write.
- R3: A write to the address register that is not selected stores its value, which reads back unchanged, and does not launch a transfer.
- R4: On a launch the hardware sets mode bit 0 (start). Mode bit 0 reads 1 while busy and returns to 0 when the transfer ends.
- R5: A transfer copies count bytes in ascending order. Each byte is one read from source+k followed by one write to destination+k, and the byte just past the end is not written. Busy clears after the last write is acknowledged.
- R6: Abort acts only on a 0-to-1 change of mode bit 1. Such a write ends the transfer, clears busy and sets status bit 3, while done stays 0. A mode write that leaves bit 1 at 1 has no effect on a running transfer.
- R7: An error response from the memory port clears busy and sets the sticky status bit 2. Writing 1 to bit 2 clears it.
- R8: Normal completion sets the sticky status bit 1, and writing 1 to it clears it. `irq` is high exactly when status bit 1 and mode bit 5 are both 1.
- R9: A write to the launching address register while busy is ignored. The register keeps its old value and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_attr | output | ATW | Attribute of the current side |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, qualified by mem_ack |
| irq | output | 1 | End-of-segment interrupt |

## Verification
The assertions take three things for granted about the inputs:
- `mem_ack` and `mem_err` arrive only as answers to an asserted `mem_req`.
- Software never writes 1 to a sticky status bit in the same cycle that the hardware sets it.
- An abort edge and an error response never fall in the same cycle.

The bench memory acknowledges only a request that is still raised, and it takes two cycles per access. The bench issues status clears only while the channel is idle. It places each abort several cycles away from any memory error.

// File: rtl/dma_direct_ctrl.sv
module dma_direct_ctrl #(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int ATW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [7:0]     mem_wdata,
  output logic [ATW-1:0] mem_attr,
  input  logic [7:0]     mem_rdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  output logic           irq
);
  localparam logic [2:0] A_MODE = 3'd0, A_STAT = 3'd1, A_SRC = 3'd2, A_DST = 3'd3,
                         A_CNT = 3'd4, A_SAT = 3'd5, A_DAT = 3'd6;
  localparam int B_ABT = 1, B_DIR = 2, B_SWS = 3, B_SEL = 4, B_IE = 5;

  logic [5:1]     mode_q;
  logic           start_q, busy_q, done_q, err_q, abt_q, phase_q;
  logic [AW-1:0]  src_q, dst_q, wsrc, wdst;
  logic [CW-1:0]  cnt_q, wcnt;
  logic [ATW-1:0] sat_q, dat_q;
  logic [7:0]     data_q;
  logic           unused_bits;

  wire wr_mode = reg_we && reg_addr == A_MODE;
  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire wr_src  = reg_we && reg_addr == A_SRC;
  wire wr_dst  = reg_we && reg_addr == A_DST;
  wire direct  = mode_q[B_DIR] && mode_q[B_SWS];
  wire src_trg = direct && mode_q[B_SEL];
  wire dst_trg = direct && !mode_q[B_SEL];
  wire launch  = !busy_q && ((wr_src && src_trg) || (wr_dst && dst_trg));
  wire abort_e = busy_q && wr_mode && reg_wdata[B_ABT] && !mode_q[B_ABT];
  wire take_src = wr_src && !(busy_q && src_trg);
  wire take_dst = wr_dst && !(busy_q && dst_trg);

  assign unused_bits = &{1'b0, reg_wdata};
  assign mem_req   = busy_q && wcnt != '0;
  assign mem_we    = phase_q;
  assign mem_addr  = phase_q ? wdst : wsrc;
  assign mem_wdata = data_q;
  assign mem_attr  = phase_q ? dat_q : sat_q;
  assign irq       = done_q && mode_q[B_IE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      sat_q  <= '0;
      dat_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[5:1];
      if (take_src) src_q <= reg_wdata[AW-1:0];
      if (take_dst) dst_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == A_CNT) cnt_q <= reg_wdata[CW-1:0];
      if (reg_we && reg_addr == A_SAT) sat_q <= reg_wdata[ATW-1:0];
      if (reg_we && reg_addr == A_DAT) dat_q <= reg_wdata[ATW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      abt_q   <= 1'b0;
      phase_q <= 1'b0;
      wsrc    <= '0;
      wdst    <= '0;
      wcnt    <= '0;
      data_q  <= '0;
    end else begin
      if (wr_stat) begin
        if (reg_wdata[1]) done_q <= 1'b0;
        if (reg_wdata[2]) err_q  <= 1'b0;
        if (reg_wdata[3]) abt_q  <= 1'b0;
      end
      if (launch) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        phase_q <= 1'b0;
        wsrc    <= wr_src ? reg_wdata[AW-1:0] : src_q;
        wdst    <= wr_dst ? reg_wdata[AW-1:0] : dst_q;
        wcnt    <= cnt_q;
      end else if (busy_q) begin
        if (abort_e) begin
          busy_q  <= 1'b0;
          start_q <= 1'b0;
          abt_q   <= 1'b1;
        end else if (wcnt == '0) begin
          busy_q  <= 1'b0;
          start_q <= 1'b0;
          done_q  <= 1'b1;
        end else if (mem_ack) begin
          if (mem_err) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            err_q   <= 1'b1;
          end else if (!phase_q) begin
            data_q  <= mem_rdata;
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            wsrc    <= wsrc + 1'b1;
            wdst    <= wdst + 1'b1;
            wcnt    <= wcnt - 1'b1;
            if (wcnt == CW'(1)) begin
              busy_q  <= 1'b0;
              start_q <= 1'b0;
              done_q  <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = 32'({mode_q, start_q});
      A_STAT:  reg_rdata = 32'({abt_q, err_q, done_q, busy_q});
      A_SRC:   reg_rdata = 32'(src_q);
      A_DST:   reg_rdata = 32'(dst_q);
      A_CNT:   reg_rdata = 32'(cnt_q);
      A_SAT:   reg_rdata = 32'(sat_q);
      A_DAT:   reg_rdata = 32'(dat_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_direct_ctrl_sva.sv
module dma_direct_ctrl_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        busy,
  input logic        start,
  input logic        done_s,
  input logic        err_s,
  input logic        abt_s,
  input logic        abt_mode
);
  wire abort_wr = reg_we && reg_addr == 3'd0 && reg_wdata[1] && !abt_mode;

  assert_launch_by_addr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we) && ($past(reg_addr) == 3'd2 || $past(reg_addr) == 3'd3));

  assert_req_only_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_start_set_by_hw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> start);

  assert_abort_edge_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort_wr) |=> !busy && abt_s);

  assert_error_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_req && mem_ack && mem_err && !abort_wr) |=> !busy && err_s);

  assert_done_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_s) |-> $fell(busy));
endmodule

bind dma_direct_ctrl dma_direct_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
  .busy(busy_q), .start(start_q), .done_s(done_q), .err_s(err_q), .abt_s(abt_q),
  .abt_mode(mode_q[1])
);

// File: tb/dma_direct_ctrl_bench.sv
module dma_direct_ctrl_bench;
  localparam int AW = 16, CW = 16, ATW = 4;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [ATW-1:0] mem_attr;
  logic irq;
  logic [7:0] mem [256];
  logic err_en = 0;
  logic [7:0] err_addr = 0;
  int checks = 0, fails = 0, cycles = 0, reqs = 0;

  always #5 clk = ~clk;

  dma_direct_ctrl #(.AW(AW), .CW(CW), .ATW(ATW)) u_dma_direct_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_attr(mem_attr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq));

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37) ^ 8'hA5);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req) reqs <= reqs + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem_ack <= 0; mem_err <= 0; mem_rdata <= 0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_err   <= mem_req && !mem_ack && err_en && mem_addr[7:0] == err_addr;
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_req && mem_ack && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  always @(posedge clk) if (cycles > 150000) begin
    checks++; fails++;
    $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] mw(bit dir, bit sws, bit sel, bit ie, bit abt);
    return 32'({ie, sel, sws, dir, abt, 1'b0});
  endfunction

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n = 0;
    rd(3'd1, s);
    while (s[0] && n < 2000) begin @(negedge clk); rd(3'd1, s); n++; end
    chk(n < 2000, req, 32'(s[0]), 0);
  endtask

  initial begin
    logic [31:0] v, m;
    int r0;
    logic [7:0] beyond;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, v); chk(v == 0, "reset mode", v, 0);
    rd(3'd1, v); chk(v == 0, "reset status", v, 0);
    chk(irq == 0, "reset irq", 32'(irq), 0);

    // R1: no launch unless direct and single-write enable are both set
    for (int cfg = 0; cfg < 3; cfg++) begin
      r0 = reqs;
      wr(3'd4, 4);
      wr(3'd0, mw(cfg[0], cfg[1], 1, 0, 0));
      wr(3'd2, 16); wr(3'd3, 32);
      @(negedge clk);
      rd(3'd1, v);
      chk(v[0] == 0 && reqs == r0, "R1 no launch", v, 0);
    end

    // R3: non-selected register write stores only
    wr(3'd0, mw(1, 1, 1, 0, 0));
    wr(3'd3, 16'h0055);
    @(negedge clk);
    rd(3'd1, v); chk(v[0] == 0, "R3 no launch on dst", v, 0);
    rd(3'd3, v); chk(v == 32'h55, "R3 dst stored", v, 32'h55);
    wr(3'd0, mw(1, 1, 0, 0, 0));
    wr(3'd2, 16'h0033);
    @(negedge clk);
    rd(3'd1, v); chk(v[0] == 0, "R3 no launch on src", v, 0);
    rd(3'd2, v); chk(v == 32'h33, "R3 src stored", v, 32'h33);

    // R2 R4 R5 R8 sweep
    for (int sel = 0; sel < 2; sel++)
      for (int ie = 0; ie < 2; ie++)
        for (int n = 1; n <= 6; n++) begin
          int s = 16 + sel * 40 + ie * 20 + n;
          int d = 128 + n;
          beyond = mem[d + n];
          wr(3'd4, n);
          wr(3'd0, mw(1, 1, sel[0], ie[0], 0));
          if (sel) begin wr(3'd3, d); reg_we = 1; reg_addr = 3'd2; reg_wdata = s; end
          else     begin wr(3'd2, s); reg_we = 1; reg_addr = 3'd3; reg_wdata = d; end
          @(negedge clk); reg_we = 0;
          rd(3'd1, v); chk(v[0] == 1, "R2 busy after launch", v, 1);
          rd(3'd0, m); chk(m[0] == 1, "R4 start bit set", m, 1);
          wait_idle("R5 completes");
          rd(3'd0, m); chk(m[0] == 0, "R4 start bit cleared", m, 0);
          for (int k = 0; k < n; k++)
            chk(mem[d + k] == pat(s + k), "R5 data", mem[d + k], pat(s + k));
          chk(mem[d + n] == beyond, "R5 no overrun", mem[d + n], beyond);
          rd(3'd1, v); chk(v[3:0] == 4'b0010, "R8 done set", v, 2);
          chk(irq == ie[0], "R8 irq gate", 32'(irq), ie);
          wr(3'd1, 32'h2);
          rd(3'd1, v); chk(v[1] == 0 && irq == 0, "R8 done cleared", v, 0);
        end

    // R9: launching write while busy ignored
    wr(3'd4, 20);
    wr(3'd0, mw(1, 1, 1, 0, 0));
    wr(3'd3, 160);
    wr(3'd2, 10);
    repeat (5) @(negedge clk);
    wr(3'd2, 99);
    rd(3'd2, v); chk(v == 10, "R9 src kept", v, 10);
    wait_idle("R9 completes");
    r0 = reqs;
    repeat (10) @(negedge clk);
    rd(3'd1, v); chk(v[0] == 0 && reqs == r0, "R9 no second transfer", v, 0);
    chk(mem[179] == pat(29), "R9 used original src", mem[179], pat(29));
    wr(3'd1, 32'hE);

    // R6: abort on rising edge only
    wr(3'd4, 40);
    wr(3'd0, mw(1, 1, 1, 0, 0));
    wr(3'd2, 20);
    repeat (10) @(negedge clk);
    wr(3'd0, mw(1, 1, 1, 0, 1));
    rd(3'd1, v); chk(v[3:0] == 4'b1000, "R6 abort stops", v, 8);
    wr(3'd1, 32'h8);
    wr(3'd4, 8);
    wr(3'd2, 30);
    repeat (6) @(negedge clk);
    wr(3'd0, mw(1, 1, 1, 0, 1));
    rd(3'd1, v); chk(v[0] == 1, "R6 level no effect", v, 1);
    wait_idle("R6 completes");
    rd(3'd1, v); chk(v[3:0] == 4'b0010, "R6 done not aborted", v, 2);
    wr(3'd1, 32'hE);

    // R7: error response
    err_en = 1; err_addr = 8'd62;
    wr(3'd4, 10);
    wr(3'd0, mw(1, 1, 1, 1, 0));
    wr(3'd2, 60);
    wait_idle("R7 stops");
    rd(3'd1, v); chk(v[3:0] == 4'b0100, "R7 error set", v, 4);
    chk(irq == 0, "R7 no irq", 32'(irq), 0);
    err_en = 0;
    wr(3'd1, 32'h4);
    rd(3'd1, v); chk(v[2] == 0, "R7 error cleared", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule